// File: doc/BRIEF.md
# Virtualized Trap Cause Selector

This block decides, for one instruction at a time, whether a synchronous trap must be taken and which cause code goes with it, on a processor core that supports a hypervisor. Its inputs are the virtualization bit, the current privilege level, a pre-decoded instruction class, the CSR number and its write intent, the three counter-enable masks (machine, hypervisor, supervisor), the trap-control bits of the machine level and of the hypervisor, the floating-point and vector state fields of the host and guest status registers, and the fault flags that the fetch and memory stages have already found.

The main job is to separate two kinds of blocked instruction. An instruction that would run in HS-mode, taking the machine-level SRET and VM trap bits as clear, but is stopped only by a virtualization control raises the virtual-instruction cause (22). Anything that would fail even in HS-mode raises illegal-instruction (2). Floating-point and vector work blocked by an Off state field is always illegal-instruction. The block also produces the guest ecall cause and the three guest-page-fault causes in their place in the priority order. The result is registered, so it appears one clock after the inputs. The block writes no trap CSRs and performs no address translation.

Top module: `trap_cause_sel`

## Requirements
- R1: After a synchronous active-low reset, and in the cycle after any cycle with `req_valid` low, `trap_valid` is 0 and `trap_cause` is 0. Otherwise the outputs for the inputs sampled at one rising edge appear after that edge, and `trap_valid` is 1 exactly when `trap_cause` is nonzero.
- R2: An instruction page fault (`ifetch_pf`, cause 12) beats an instruction guest-page fault (`ifetch_gpf`, cause 20). Either of them beats every other cause, so no illegal or virtual cause is raised while a fetch fault is pending.
- R3: Cause 2 is raised, whatever the virtualization bit, when the instruction cannot run even in HS-mode. This covers class 1 or classes 10 to 15 (unimplemented), a CSR number not implemented, a write to a read-only CSR (number bits 11:10 = 11), and a machine CSR (number bits 9:8 = 11) outside M-mode. It also covers HS-mode WFI with `trap_wfi_m`, HS-mode SRET with `trap_sret_m`, and HS-mode fence (class 5) or `satp` (0x180) with `trap_vm_m`. Privilege encoding: 0 user, 1 supervisor, 3 machine. Class codes: 0 plain, 1 unimplemented, 2 ecall, 3 WFI, 4 SRET, 5 supervisor fence/invalidate, 6 hypervisor instruction, 7 CSR access, 8 floating-point, 9 vector.
- R4: Counter CSRs 0xC00 to 0xC1F use bit (number mod 32) of the masks. A clear machine bit gives 2 outside M-mode. In U-mode a clear supervisor bit gives 2. In VS-mode a clear hypervisor bit gives 22. In VU-mode a clear hypervisor or supervisor bit gives 22.
- R5: Hypervisor-level CSRs (number bits 9:8 = 10) and class 6 give 22 from VS or VU, give 2 from U, and are accepted in HS and M.
- R6: From VU, a supervisor CSR (number bits 9:8 = 01), SRET or a class 5 fence gives 22.
- R7: WFI gives 2 in U-mode and gives 2 with `trap_wfi_m` set outside M-mode. With `trap_wfi_m` clear it gives 22 in VU, and in VS when `guest_trap_wfi` is set.
- R8: In VS, SRET gives 22 when `guest_trap_sret` is set. A fence (class 5) or a `satp` access gives 22 when `guest_trap_vm` is set. The machine-level bits do not affect VS.
- R9: With parameter XLEN = 32, counter CSRs 0xC80 to 0xC9F follow R4 with bit (number mod 32). With XLEN = 64 they are unimplemented and give 2.
- R10: A floating-point instruction (class 8) or CSR 0x001 to 0x003 gives 2 when the host FP state is Off (2'b00), or when V=1 and the guest FP state is Off. Vector (class 9) does the same with the vector fields. Cause 22 is never raised for these.
- R11: Ecall gives 8 from U or VU, 9 from HS, 10 from VS and 11 from M. It ranks below illegal and virtual.
- R12: Memory faults rank below ecall, in the order load page fault 13, load guest-page fault 21, store page fault 15, store guest-page fault 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An instruction is presented this cycle |
| virt_on | input | 1 | Virtualization bit V |
| prv | input | 2 | Privilege level (0 U, 1 S, 3 M) |
| iclass | input | 4 | Pre-decoded instruction class |
| csr_num | input | 12 | CSR number for class 7 |
| csr_wr | input | 1 | The CSR access writes |
| cnt_en_m | input | NUM_CTR | Machine counter-enable mask |
| cnt_en_h | input | NUM_CTR | Hypervisor counter-enable mask |
| cnt_en_s | input | NUM_CTR | Supervisor counter-enable mask |
| trap_wfi_m | input | 1 | Machine-level WFI trap bit |
| trap_vm_m | input | 1 | Machine-level VM trap bit |
| trap_sret_m | input | 1 | Machine-level SRET trap bit |
| guest_trap_wfi | input | 1 | Hypervisor WFI trap bit for VS |
| guest_trap_vm | input | 1 | Hypervisor VM trap bit for VS |
| guest_trap_sret | input | 1 | Hypervisor SRET trap bit for VS |
| fp_state_host | input | 2 | Host FP state field |
| vec_state_host | input | 2 | Host vector state field |
| fp_state_guest | input | 2 | Guest FP state field |
| vec_state_guest | input | 2 | Guest vector state field |
| ifetch_pf | input | 1 | Instruction page fault pending |
| ifetch_gpf | input | 1 | Instruction guest-page fault pending |
| ld_pf | input | 1 | Load page fault |
| ld_gpf | input | 1 | Load guest-page fault |
| st_pf | input | 1 | Store page fault |
| st_gpf | input | 1 | Store guest-page fault |
| trap_valid | output | 1 | A trap is to be taken |
| trap_cause | output | 5 | Cause code, 0 when no trap |

## Verification
The assertions take for granted that the virtualization bit is never set together with machine privilege, and that privilege value 2 is never presented, since neither state exists on a real hart. They also take the pre-decoded class and CSR number as belonging to one instruction, so a fetch fault arriving with a garbage class is still expected to win. The stimulus draws privilege only from 0, 1 and 3 and forces V to 0 whenever it picks M-mode. Random CSR numbers come from a pool of counter, high-half, FP, supervisor, hypervisor, machine and unimplemented numbers, so every branch of the classification is reached without leaving those assumptions.

// File: rtl/tcs_pkg.sv
// Package: shared encodings for the trap cause selector.
// Assumes privilege values 0, 1 and 3 only; class codes 10..15 are unimplemented.
package tcs_pkg;

    localparam int CTR_NUM   = 32;
    localparam int CAUSE_W   = 5;

    typedef enum logic [3:0] {
        IC_PLAIN  = 4'd0,
        IC_UNIMPL = 4'd1,
        IC_ECALL  = 4'd2,
        IC_WFI    = 4'd3,
        IC_SRET   = 4'd4,
        IC_FENCE  = 4'd5,
        IC_HYPER  = 4'd6,
        IC_CSR    = 4'd7,
        IC_FP     = 4'd8,
        IC_VEC    = 4'd9
    } iclass_e;

    typedef enum logic [2:0] {
        MD_U, MD_HS, MD_M, MD_VU, MD_VS
    } mode_e;

    localparam logic [CAUSE_W-1:0] CS_NONE      = 5'd0;
    localparam logic [CAUSE_W-1:0] CS_ILLEGAL   = 5'd2;
    localparam logic [CAUSE_W-1:0] CS_ECALL_U   = 5'd8;
    localparam logic [CAUSE_W-1:0] CS_ECALL_HS  = 5'd9;
    localparam logic [CAUSE_W-1:0] CS_ECALL_VS  = 5'd10;
    localparam logic [CAUSE_W-1:0] CS_ECALL_M   = 5'd11;
    localparam logic [CAUSE_W-1:0] CS_IPF       = 5'd12;
    localparam logic [CAUSE_W-1:0] CS_LPF       = 5'd13;
    localparam logic [CAUSE_W-1:0] CS_SPF       = 5'd15;
    localparam logic [CAUSE_W-1:0] CS_IGPF      = 5'd20;
    localparam logic [CAUSE_W-1:0] CS_LGPF      = 5'd21;
    localparam logic [CAUSE_W-1:0] CS_VIRT      = 5'd22;
    localparam logic [CAUSE_W-1:0] CS_SGPF      = 5'd23;

    // Decoded properties of one CSR number.
    typedef struct packed {
        logic       known;
        logic       read_only;
        logic       is_ctr;
        logic       is_fp;
        logic       is_satp;
        logic [1:0] lvl;
    } csr_info_t;

endpackage

// File: rtl/tcs_csr_decode.sv
// Module: tcs_csr_decode
// Classifies a CSR number: implemented or not, read-only, counter (with its
// mask index), FP CSR, address-translation CSR, and required privilege level.
// Assumes counters form one aligned block of NUM_CTR numbers per half.
module tcs_csr_decode
    import tcs_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_CTR = CTR_NUM
) (
    input  logic [11:0]                  csr_num,
    output csr_info_t                    info,
    output logic [$clog2(NUM_CTR)-1:0]   ctr_idx
);
    localparam int          IDX_W    = $clog2(NUM_CTR);
    localparam logic [11:0] LO_BASE  = 12'hC00;
    localparam logic [11:0] HI_BASE  = 12'hC80;
    localparam logic [11:0] SATP_NUM = 12'h180;
    localparam logic        HAS_HIGH = (XLEN == 32);

    logic lo_ctr;
    logic hi_ctr;
    logic fp_csr;

    // Decode the number into its class bits.
    always_comb begin
        lo_ctr         = (csr_num >> IDX_W) == (LO_BASE >> IDX_W);
        hi_ctr         = ((csr_num >> IDX_W) == (HI_BASE >> IDX_W)) & HAS_HIGH;
        fp_csr         = (csr_num >= 12'h001) && (csr_num <= 12'h003);
        info.lvl       = csr_num[9:8];
        info.is_ctr    = lo_ctr | hi_ctr;
        info.is_fp     = fp_csr;
        info.is_satp   = (csr_num == SATP_NUM);
        info.read_only = (csr_num[11:10] == 2'b11);
        info.known     = lo_ctr | hi_ctr | fp_csr | (csr_num[9:8] != 2'b00);
        ctr_idx        = csr_num[IDX_W-1:0];
    end

endmodule

// File: rtl/tcs_rule.sv
// Module: tcs_rule
// Applies the legality rules per effective mode and raises either the
// illegal flag or the virtual flag (never both), plus the ecall flag/cause.
// Assumes V is never set with machine privilege; privilege 2 acts as M.
module tcs_rule
    import tcs_pkg::*;
#(
    parameter int NUM_CTR = CTR_NUM
) (
    input  logic                        virt_on,
    input  logic [1:0]                  prv,
    input  logic [3:0]                  iclass,
    input  csr_info_t                   info,
    input  logic [$clog2(NUM_CTR)-1:0]  ctr_idx,
    input  logic                        csr_wr,
    input  logic [NUM_CTR-1:0]          cnt_en_m,
    input  logic [NUM_CTR-1:0]          cnt_en_h,
    input  logic [NUM_CTR-1:0]          cnt_en_s,
    input  logic                        trap_wfi_m,
    input  logic                        trap_vm_m,
    input  logic                        trap_sret_m,
    input  logic                        guest_trap_wfi,
    input  logic                        guest_trap_vm,
    input  logic                        guest_trap_sret,
    input  logic [1:0]                  fp_state_host,
    input  logic [1:0]                  vec_state_host,
    input  logic [1:0]                  fp_state_guest,
    input  logic [1:0]                  vec_state_guest,
    output logic                        ill,
    output logic                        vins,
    output logic                        ecall,
    output logic [CAUSE_W-1:0]          ecall_cause
);
    mode_e mode;
    logic  fp_off;
    logic  vec_off;
    logic  en_m, en_h, en_s;
    logic  guest;

    // Effective mode and the shared state-field checks.
    always_comb begin
        if (prv[1])       mode = MD_M;
        else if (virt_on) mode = prv[0] ? MD_VS : MD_VU;
        else              mode = prv[0] ? MD_HS : MD_U;
        guest   = (mode == MD_VS) || (mode == MD_VU);
        fp_off  = (fp_state_host == 2'b00)  || (guest && fp_state_guest == 2'b00);
        vec_off = (vec_state_host == 2'b00) || (guest && vec_state_guest == 2'b00);
        en_m    = cnt_en_m[ctr_idx];
        en_h    = cnt_en_h[ctr_idx];
        en_s    = cnt_en_s[ctr_idx];
    end

    // Per-class legality: illegal when even HS-mode fails, virtual otherwise.
    always_comb begin
        ill  = 1'b0;
        vins = 1'b0;
        case (iclass)
            IC_PLAIN, IC_ECALL: ;
            IC_WFI: begin
                case (mode)
                    MD_HS:   ill = trap_wfi_m;
                    MD_U:    ill = 1'b1;
                    MD_VS:   begin ill = trap_wfi_m; vins = !trap_wfi_m && guest_trap_wfi; end
                    MD_VU:   begin ill = trap_wfi_m; vins = !trap_wfi_m; end
                    default: ;
                endcase
            end
            IC_SRET: begin
                case (mode)
                    MD_HS:   ill  = trap_sret_m;
                    MD_U:    ill  = 1'b1;
                    MD_VS:   vins = guest_trap_sret;
                    MD_VU:   vins = 1'b1;
                    default: ;
                endcase
            end
            IC_FENCE: begin
                case (mode)
                    MD_HS:   ill  = trap_vm_m;
                    MD_U:    ill  = 1'b1;
                    MD_VS:   vins = guest_trap_vm;
                    MD_VU:   vins = 1'b1;
                    default: ;
                endcase
            end
            IC_HYPER: begin
                ill  = (mode == MD_U);
                vins = guest;
            end
            IC_FP:  ill = fp_off;
            IC_VEC: ill = vec_off;
            IC_CSR: begin
                if (!info.known || (csr_wr && info.read_only)) begin
                    ill = 1'b1;
                end else if (info.is_fp) begin
                    ill = fp_off;
                end else if (info.is_ctr) begin
                    if (mode != MD_M) begin
                        if (!en_m)                           ill  = 1'b1;
                        else if (mode == MD_U && !en_s)      ill  = 1'b1;
                        else if (mode == MD_VS && !en_h)     vins = 1'b1;
                        else if (mode == MD_VU && !(en_h && en_s)) vins = 1'b1;
                    end
                end else begin
                    case (info.lvl)
                        2'b11: ill = (mode != MD_M);
                        2'b10: begin
                            ill  = (mode == MD_U);
                            vins = guest;
                        end
                        2'b01: begin
                            case (mode)
                                MD_U:    ill  = 1'b1;
                                MD_VU:   vins = 1'b1;
                                MD_HS:   ill  = info.is_satp && trap_vm_m;
                                MD_VS:   vins = info.is_satp && guest_trap_vm;
                                default: ;
                            endcase
                        end
                        default: ;
                    endcase
                end
            end
            default: ill = 1'b1;
        endcase
    end

    // Environment call cause by originating mode.
    always_comb begin
        ecall = (iclass == IC_ECALL);
        case (mode)
            MD_M:    ecall_cause = CS_ECALL_M;
            MD_HS:   ecall_cause = CS_ECALL_HS;
            MD_VS:   ecall_cause = CS_ECALL_VS;
            default: ecall_cause = CS_ECALL_U;
        endcase
    end

endmodule

// File: rtl/tcs_prio.sv
// Module: tcs_prio
// Picks the single winning cause from the fault flags and the rule outputs.
// Order: fetch PF, fetch GPF, illegal, virtual, ecall, load PF, load GPF,
// store PF, store GPF. Assumes the rule outputs are mutually exclusive.
module tcs_prio
    import tcs_pkg::*;
(
    input  logic               req_valid,
    input  logic               ifetch_pf,
    input  logic               ifetch_gpf,
    input  logic               ill,
    input  logic               vins,
    input  logic               ecall,
    input  logic [CAUSE_W-1:0] ecall_cause,
    input  logic               ld_pf,
    input  logic               ld_gpf,
    input  logic               st_pf,
    input  logic               st_gpf,
    output logic               hit,
    output logic [CAUSE_W-1:0] cause
);
    // Fixed-priority selection of the cause code.
    always_comb begin
        if (!req_valid)      cause = CS_NONE;
        else if (ifetch_pf)  cause = CS_IPF;
        else if (ifetch_gpf) cause = CS_IGPF;
        else if (ill)        cause = CS_ILLEGAL;
        else if (vins)       cause = CS_VIRT;
        else if (ecall)      cause = ecall_cause;
        else if (ld_pf)      cause = CS_LPF;
        else if (ld_gpf)     cause = CS_LGPF;
        else if (st_pf)      cause = CS_SPF;
        else if (st_gpf)     cause = CS_SGPF;
        else                 cause = CS_NONE;
        hit = (cause != CS_NONE);
    end

endmodule

// File: rtl/trap_cause_sel.sv
// Module: trap_cause_sel (top)
// Classifies the presented instruction into a trap cause and registers the
// result for one cycle. Assumes inputs are stable around the rising edge.
module trap_cause_sel
    import tcs_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_CTR = CTR_NUM
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               virt_on,
    input  logic [1:0]         prv,
    input  logic [3:0]         iclass,
    input  logic [11:0]        csr_num,
    input  logic               csr_wr,
    input  logic [NUM_CTR-1:0] cnt_en_m,
    input  logic [NUM_CTR-1:0] cnt_en_h,
    input  logic [NUM_CTR-1:0] cnt_en_s,
    input  logic               trap_wfi_m,
    input  logic               trap_vm_m,
    input  logic               trap_sret_m,
    input  logic               guest_trap_wfi,
    input  logic               guest_trap_vm,
    input  logic               guest_trap_sret,
    input  logic [1:0]         fp_state_host,
    input  logic [1:0]         vec_state_host,
    input  logic [1:0]         fp_state_guest,
    input  logic [1:0]         vec_state_guest,
    input  logic               ifetch_pf,
    input  logic               ifetch_gpf,
    input  logic               ld_pf,
    input  logic               ld_gpf,
    input  logic               st_pf,
    input  logic               st_gpf,
    output logic               trap_valid,
    output logic [4:0]         trap_cause
);
    localparam int IDX_W = $clog2(NUM_CTR);

    csr_info_t            info;
    logic [IDX_W-1:0]     ctr_idx;
    logic                 ill, vins, ecall, hit;
    logic [CAUSE_W-1:0]   ecall_cause, cause;

    tcs_csr_decode #(.XLEN(XLEN), .NUM_CTR(NUM_CTR)) dec_i (
        .csr_num (csr_num),
        .info    (info),
        .ctr_idx (ctr_idx)
    );

    tcs_rule #(.NUM_CTR(NUM_CTR)) rule_i (
        .virt_on         (virt_on),
        .prv             (prv),
        .iclass          (iclass),
        .info            (info),
        .ctr_idx         (ctr_idx),
        .csr_wr          (csr_wr),
        .cnt_en_m        (cnt_en_m),
        .cnt_en_h        (cnt_en_h),
        .cnt_en_s        (cnt_en_s),
        .trap_wfi_m      (trap_wfi_m),
        .trap_vm_m       (trap_vm_m),
        .trap_sret_m     (trap_sret_m),
        .guest_trap_wfi  (guest_trap_wfi),
        .guest_trap_vm   (guest_trap_vm),
        .guest_trap_sret (guest_trap_sret),
        .fp_state_host   (fp_state_host),
        .vec_state_host  (vec_state_host),
        .fp_state_guest  (fp_state_guest),
        .vec_state_guest (vec_state_guest),
        .ill             (ill),
        .vins            (vins),
        .ecall           (ecall),
        .ecall_cause     (ecall_cause)
    );

    tcs_prio prio_i (
        .req_valid   (req_valid),
        .ifetch_pf   (ifetch_pf),
        .ifetch_gpf  (ifetch_gpf),
        .ill         (ill),
        .vins        (vins),
        .ecall       (ecall),
        .ecall_cause (ecall_cause),
        .ld_pf       (ld_pf),
        .ld_gpf      (ld_gpf),
        .st_pf       (st_pf),
        .st_gpf      (st_gpf),
        .hit         (hit),
        .cause       (cause)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_cause <= '0;
        end else begin
            trap_valid <= hit;
            trap_cause <= cause;
        end
    end

endmodule

// File: rtl/tcs_chk.sv
// Module: tcs_chk
// Assertion checker bound to trap_cause_sel; relates registered outputs to
// the inputs sampled one edge earlier. Assumes V=0 whenever privilege is M.
module tcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       virt_on,
    input logic [1:0] prv,
    input logic [3:0] iclass,
    input logic [1:0] fp_state_host,
    input logic       ifetch_pf,
    input logic       ifetch_gpf,
    input logic       trap_valid,
    input logic [4:0] trap_cause
);
    // R1: idle cycle leaves no trap behind
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(req_valid) |-> !trap_valid && trap_cause == 5'd0);

    // R1: valid flag agrees with a nonzero cause
    assert_valid_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid == (trap_cause != 5'd0));

    // R2: instruction page fault wins over everything
    assert_fetch_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && $past(ifetch_pf) |-> trap_cause == 5'd12);

    // R3: unimplemented class is illegal when no fetch fault is pending
    assert_unimpl_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && !ifetch_pf && !ifetch_gpf && iclass == 4'd1)
        |-> trap_cause == 5'd2);

    // R5: virtual instruction only follows a cycle with V set
    assert_virt_needs_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && trap_cause == 5'd22 |-> $past(virt_on));

    // R10: FP with host state Off is always illegal
    assert_fp_carveout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_valid && !ifetch_pf && !ifetch_gpf && iclass == 4'd8
              && fp_state_host == 2'b00) |-> trap_cause == 5'd2);

    // R11: guest ecall cause only from VS with an ecall
    assert_vs_ecall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && trap_cause == 5'd10 |-> $past(virt_on && prv == 2'd1 && iclass == 4'd2));

endmodule

bind trap_cause_sel tcs_chk chk_i (.*);

// File: tb/trap_cause_sel_tb_top.sv
`timescale 1ns/1ps
module trap_cause_sel_tb_top;

    typedef struct {
        logic        valid, virt;
        logic [1:0]  priv;
        logic [3:0]  cls;
        logic [11:0] csr;
        logic        wr;
        logic [31:0] mcen, hcen, scen;
        logic        tw, tvm, tsr, vtw, vtvm, vtsr;
        logic [1:0]  sfs, svs, gfs, gvs;
        logic        ipf, igpf, lpf, lgpf, spf, sgpf;
    } stim_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    stim_t cur;
    logic tv32, tv64;
    logic [4:0] tc32, tc64;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trap_cause_sel dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(cur.valid), .virt_on(cur.virt),
        .prv(cur.priv), .iclass(cur.cls), .csr_num(cur.csr), .csr_wr(cur.wr),
        .cnt_en_m(cur.mcen), .cnt_en_h(cur.hcen), .cnt_en_s(cur.scen),
        .trap_wfi_m(cur.tw), .trap_vm_m(cur.tvm), .trap_sret_m(cur.tsr),
        .guest_trap_wfi(cur.vtw), .guest_trap_vm(cur.vtvm), .guest_trap_sret(cur.vtsr),
        .fp_state_host(cur.sfs), .vec_state_host(cur.svs),
        .fp_state_guest(cur.gfs), .vec_state_guest(cur.gvs),
        .ifetch_pf(cur.ipf), .ifetch_gpf(cur.igpf), .ld_pf(cur.lpf), .ld_gpf(cur.lgpf),
        .st_pf(cur.spf), .st_gpf(cur.sgpf), .trap_valid(tv32), .trap_cause(tc32));

    trap_cause_sel #(.XLEN(64)) dut64_i (
        .clk(clk), .rst_n(rst_n), .req_valid(cur.valid), .virt_on(cur.virt),
        .prv(cur.priv), .iclass(cur.cls), .csr_num(cur.csr), .csr_wr(cur.wr),
        .cnt_en_m(cur.mcen), .cnt_en_h(cur.hcen), .cnt_en_s(cur.scen),
        .trap_wfi_m(cur.tw), .trap_vm_m(cur.tvm), .trap_sret_m(cur.tsr),
        .guest_trap_wfi(cur.vtw), .guest_trap_vm(cur.vtvm), .guest_trap_sret(cur.vtsr),
        .fp_state_host(cur.sfs), .vec_state_host(cur.svs),
        .fp_state_guest(cur.gfs), .vec_state_guest(cur.gvs),
        .ifetch_pf(cur.ipf), .ifetch_gpf(cur.igpf), .ld_pf(cur.lpf), .ld_gpf(cur.lgpf),
        .st_pf(cur.spf), .st_gpf(cur.sgpf), .trap_valid(tv64), .trap_cause(tc64));

    // Reference model: legality in HS-mode versus legality in the current mode.
    function automatic void model(input stim_t s, input int xlen,
                                  output logic [4:0] c, output string tag);
        bit m  = (s.priv == 2'd3);
        bit hs = !s.virt && s.priv == 2'd1;
        bit u  = !s.virt && s.priv == 2'd0;
        bit vs = s.virt && s.priv == 2'd1;
        int a   = int'(s.csr);
        int idx = a % 32;
        int lvl = (a >> 8) % 4;
        bit lo  = a >= 'hC00 && a <= 'hC1F;
        bit hi  = a >= 'hC80 && a <= 'hC9F;
        bit ctr = lo || (hi && xlen == 32);
        bit fpc = a >= 1 && a <= 3;
        bit known = ctr || fpc || lvl != 0;
        bit ro  = (a >> 10) == 3;
        bit satp = (a == 'h180);
        bit fpoff  = s.sfs == 0 || (s.virt && s.gfs == 0);
        bit vecoff = s.svs == 0 || (s.virt && s.gvs == 0);
        bit base_ok = known && !(s.wr && ro) && !(fpc && fpoff);
        bit hs_legal, m_legal, here, sup_ins;
        int k = int'(s.cls);
        sup_ins = (k == 3 || k == 4 || k == 5 || k == 6);
        case (k)
            0, 2, 4, 5, 6: hs_legal = 1;
            3: hs_legal = !s.tw;
            7: hs_legal = base_ok && lvl != 3 && !(ctr && !s.mcen[idx]);
            8: hs_legal = !fpoff;
            9: hs_legal = !vecoff;
            default: hs_legal = 0;
        endcase
        case (k)
            0, 2, 3, 4, 5, 6: m_legal = 1;
            7: m_legal = base_ok;
            8: m_legal = !fpoff;
            9: m_legal = !vecoff;
            default: m_legal = 0;
        endcase
        if (m) here = m_legal;
        else if (hs) here = hs_legal && !(k == 4 && s.tsr) && !(k == 5 && s.tvm)
                            && !(k == 7 && satp && s.tvm);
        else if (u) here = hs_legal && !sup_ins
                           && !(k == 7 && (lvl != 0 || (ctr && !s.scen[idx])));
        else if (vs) here = hs_legal && !(k == 3 && s.vtw) && !(k == 4 && s.vtsr)
                            && !(k == 5 && s.vtvm) && k != 6
                            && !(k == 7 && (lvl == 2 || (satp && s.vtvm) || (ctr && !s.hcen[idx])));
        else here = hs_legal && !sup_ins
                    && !(k == 7 && (lvl != 0 || (ctr && (!s.hcen[idx] || !s.scen[idx]))));
        // reason tag
        if (k == 3) tag = "R7";
        else if (k == 4 || k == 5 || (k == 7 && satp)) tag = "R8";
        else if (k == 6 || (k == 7 && lvl == 2)) tag = "R5";
        else if (k == 8 || k == 9 || (k == 7 && fpc)) tag = "R10";
        else if (k == 7 && hi) tag = "R9";
        else if (k == 7 && lo) tag = "R4";
        else if (k == 7 && lvl == 1) tag = "R6";
        else tag = "R3";
        if (!s.valid) begin c = 0; tag = "R1"; end
        else if (s.ipf) begin c = 12; tag = "R2"; end
        else if (s.igpf) begin c = 20; tag = "R2"; end
        else if (!here && !(s.virt && hs_legal)) c = 2;
        else if (!here) c = 22;
        else if (k == 2) begin
            tag = "R11";
            c = m ? 5'd11 : hs ? 5'd9 : vs ? 5'd10 : 5'd8;
        end
        else if (s.lpf)  begin c = 13; tag = "R12"; end
        else if (s.lgpf) begin c = 21; tag = "R12"; end
        else if (s.spf)  begin c = 15; tag = "R12"; end
        else if (s.sgpf) begin c = 23; tag = "R12"; end
        else begin c = 0; tag = "R1"; end
    endfunction

    task automatic compare(input string tag, input string which,
                           input logic av, input logic [4:0] ac, input logic [4:0] ec);
        n_cmp++;
        if (av !== (ec != 0) || ac !== ec) begin
            n_bad++;
            $display("FAIL %s %s: valid=%0b cause=%0d expected valid=%0b cause=%0d",
                     tag, which, av, ac, (ec != 0), ec);
        end
    endtask

    // Drive one stimulus, wait for the capturing edge, compare both variants.
    task automatic step(input stim_t s);
        logic [4:0] e32, e64;
        string t32, t64;
        bit in_rst = !rst_n;
        cur = s;
        model(s, 32, e32, t32);
        model(s, 64, e64, t64);
        @(posedge clk);
        #2;
        if (in_rst) begin
            e32 = 0; e64 = 0; t32 = "R1"; t64 = "R1";
        end
        compare(t32, "xlen32", tv32, tc32, e32);
        compare(t64, "xlen64", tv64, tc64, e64);
    endtask

    function automatic stim_t base();
        stim_t s;
        s.valid = 1; s.virt = 0; s.priv = 1; s.cls = 0; s.csr = 12'hC00; s.wr = 0;
        s.mcen = '1; s.hcen = '1; s.scen = '1;
        s.tw = 0; s.tvm = 0; s.tsr = 0; s.vtw = 0; s.vtvm = 0; s.vtsr = 0;
        s.sfs = 1; s.svs = 1; s.gfs = 1; s.gvs = 1;
        s.ipf = 0; s.igpf = 0; s.lpf = 0; s.lgpf = 0; s.spf = 0; s.sgpf = 0;
        return s;
    endfunction

    function automatic stim_t rnd();
        logic [11:0] pool [20] = '{12'hC00, 12'hC01, 12'hC02, 12'hC1F, 12'hC80, 12'hC81,
                                   12'hC9F, 12'h001, 12'h003, 12'h004, 12'h100, 12'h180,
                                   12'h141, 12'h200, 12'h600, 12'h680, 12'h7C0, 12'h300,
                                   12'hF11, 12'hC20};
        stim_t s = base();
        int p = $urandom % 3;
        s.valid = ($urandom % 8) != 0;
        s.priv = (p == 2) ? 2'd3 : 2'(p);
        s.virt = (s.priv != 3) ? 1'($urandom) : 1'b0;
        s.cls = 4'($urandom % 10);
        s.csr = pool[$urandom % 20];
        s.wr = 1'($urandom);
        s.mcen = $urandom | $urandom; s.hcen = $urandom | $urandom; s.scen = $urandom | $urandom;
        {s.tw, s.tvm, s.tsr, s.vtw, s.vtvm, s.vtsr} = 6'($urandom);
        {s.sfs, s.svs, s.gfs, s.gvs} = 8'($urandom);
        s.ipf = ($urandom % 8) == 0; s.igpf = ($urandom % 8) == 0;
        s.lpf = ($urandom % 6) == 0; s.lgpf = ($urandom % 6) == 0;
        s.spf = ($urandom % 6) == 0; s.sgpf = ($urandom % 6) == 0;
        return s;
    endfunction

    initial begin
        stim_t s;
        cur = base();
        // R1: reset holds outputs at zero even with a trapping instruction.
        rst_n = 0;
        for (int i = 0; i < 4; i++) begin s = base(); s.cls = 1; step(s); end
        rst_n = 1;
        s = base(); s.valid = 0; s.cls = 1; step(s);                   // R1 idle
        s = base(); step(s);                                           // R1 plain
        // R2 fetch faults
        s = base(); s.cls = 1; s.ipf = 1; s.igpf = 1; step(s);
        s = base(); s.virt = 1; s.cls = 6; s.igpf = 1; step(s);
        // R3 illegal regardless of V
        s = base(); s.virt = 1; s.cls = 1; step(s);
        s = base(); s.virt = 1; s.cls = 7; s.csr = 12'h7C0; step(s);
        s = base(); s.virt = 1; s.cls = 7; s.csr = 12'hC00; s.wr = 1; step(s);
        s = base(); s.cls = 12; step(s);
        // R4 counters
        s = base(); s.virt = 1; s.cls = 7; s.hcen[0] = 0; step(s);
        s = base(); s.virt = 1; s.cls = 7; s.mcen[0] = 0; s.hcen[0] = 0; step(s);
        s = base(); s.virt = 1; s.priv = 0; s.cls = 7; s.csr = 12'hC02; s.scen[2] = 0; step(s);
        s = base(); s.priv = 0; s.cls = 7; s.csr = 12'hC02; s.scen[2] = 0; step(s);
        s = base(); s.priv = 3; s.cls = 7; s.mcen = '0; step(s);
        // R5 hypervisor CSR / instruction
        s = base(); s.virt = 1; s.cls = 7; s.csr = 12'h600; step(s);
        s = base(); s.priv = 0; s.cls = 7; s.csr = 12'h600; step(s);
        s = base(); s.cls = 7; s.csr = 12'h600; step(s);
        s = base(); s.virt = 1; s.priv = 0; s.cls = 6; step(s);
        // R6 supervisor from VU
        s = base(); s.virt = 1; s.priv = 0; s.cls = 7; s.csr = 12'h100; step(s);
        s = base(); s.virt = 1; s.priv = 0; s.cls = 4; step(s);
        s = base(); s.virt = 1; s.priv = 0; s.cls = 5; step(s);
        // R7 WFI
        s = base(); s.virt = 1; s.cls = 3; s.vtw = 1; step(s);
        s = base(); s.virt = 1; s.cls = 3; step(s);
        s = base(); s.virt = 1; s.priv = 0; s.cls = 3; step(s);
        s = base(); s.virt = 1; s.priv = 0; s.cls = 3; s.tw = 1; step(s);
        s = base(); s.cls = 3; s.tw = 1; step(s);
        s = base(); s.priv = 0; s.cls = 3; step(s);
        // R8 SRET / fence / satp
        s = base(); s.virt = 1; s.cls = 4; s.vtsr = 1; step(s);
        s = base(); s.virt = 1; s.cls = 4; s.tsr = 1; step(s);
        s = base(); s.virt = 1; s.cls = 5; s.vtvm = 1; step(s);
        s = base(); s.virt = 1; s.cls = 7; s.csr = 12'h180; s.vtvm = 1; step(s);
        s = base(); s.cls = 7; s.csr = 12'h180; s.tvm = 1; step(s);
        s = base(); s.cls = 4; s.tsr = 1; step(s);
        // R9 high-half counter
        s = base(); s.virt = 1; s.cls = 7; s.csr = 12'hC81; s.hcen[1] = 0; step(s);
        s = base(); s.cls = 7; s.csr = 12'hC9F; step(s);
        // R10 FP / vector carve-out
        s = base(); s.virt = 1; s.cls = 8; s.gfs = 0; step(s);
        s = base(); s.cls = 8; s.sfs = 0; step(s);
        s = base(); s.virt = 1; s.cls = 9; s.gvs = 0; step(s);
        s = base(); s.virt = 1; s.cls = 7; s.csr = 12'h001; s.gfs = 0; step(s);
        s = base(); s.cls = 8; s.gfs = 0; step(s);
        // R11 ecall by mode
        for (int i = 0; i < 5; i++) begin
            s = base(); s.cls = 2;
            s.priv = (i == 4) ? 2'd3 : 2'(i % 2);
            s.virt = (i == 2 || i == 3);
            step(s);
        end
        // R12 memory faults
        s = base(); s.lpf = 1; s.lgpf = 1; s.spf = 1; step(s);
        s = base(); s.lgpf = 1; s.sgpf = 1; step(s);
        s = base(); s.sgpf = 1; step(s);
        s = base(); s.spf = 1; s.sgpf = 1; step(s);
        s = base(); s.cls = 1; s.lpf = 1; step(s);
        s = base(); s.cls = 2; s.lgpf = 1; step(s);
        // random mix
        for (int i = 0; i < 4000; i++) step(rnd());
        // R1 reset again mid-run
        rst_n = 0; step(rnd()); rst_n = 1;
        for (int i = 0; i < 200; i++) step(rnd());
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: cycles=150000 expected completion earlier");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule